// File: doc/BRIEF.md
# FEAC Codeword Transmit and Receive Controller

This block terminates the far-end alarm and control channel of a DS3 C-bit parity stream. It works on one bit at a time: an outside framer raises `bit_en` for each FEAC bit slot and supplies or takes the bit. The block does not handle framing or C-bit extraction. A codeword is 16 bits long, `0 c5 c4 c3 c2 c1 c0 0` followed by eight ones, and it leaves and arrives leading zero first.

The receiver hunts bit by bit for the codeword shape. Once it finds one, it checks each following 16-bit window. A code that fills at least 8 of 10 windows is accepted with no host involvement. It is reported once with a one-cycle `rx_valid` pulse and written into a four-entry FIFO. The host drains the FIFO through a show-ahead read port. The transmitter runs from a level-coded mode input. It can send one codeword 10 times, send a codeword without end, or send 10 copies of code A followed by 10 copies of code B, which is the order a loopback command needs. It sends all ones at any other time. Mode changes are applied only at codeword boundaries.

Transmit states: TX_IDLE (ones), TX_SHOT (burst of A), TX_CONT (endless A), TX_PAIR_A and TX_PAIR_B (the A and B halves of a pair burst), TX_DONE (ones after a burst). All transitions happen at a boundary. From TX_IDLE the block dispatches on the mode. TX_SHOT and TX_PAIR_B move to TX_DONE after their 10th word. TX_PAIR_A moves to TX_PAIR_B after its 10th word. TX_CONT stays while the mode is continuous. Any burst state dispatches again if the mode leaves it. TX_DONE holds until the mode goes to idle or continuous. Receive states: RX_HUNT (slide one bit at a time), RX_TRACK (count hits and misses per window), RX_HELD (code reported, 10-window history). RX_HUNT moves to RX_TRACK on a valid shape. RX_TRACK moves to RX_HELD on its 8th hit and returns to RX_HUNT on its 3rd miss. RX_HELD returns to RX_HUNT when the history falls below 8 hits. A window that holds a different valid code sends RX_TRACK or RX_HELD back to RX_TRACK for the new code.

Top module: `feac_ctrl`

## Requirements
- R1: A transmitted codeword for code c is the 16-bit word {0, c[5:0], 0, 8'hFF}, sent most significant bit first. Codeword boundaries fall every 16 `bit_en` slots, counted from reset.
- R2: After reset `tx_bit` is 1, `rd_empty` is 1, `rd_ovf` is 0 and `rx_valid` is 0. In idle mode (`tx_mode`=0) the transmitter sends all ones.
- R3: Single-burst mode (`tx_mode`=1) sends code A in exactly 10 consecutive words and then all ones until the mode leaves single-burst.
- R4: Continuous mode (`tx_mode`=2) sends code A in every word for as long as the mode is held.
- R5: Pair mode (`tx_mode`=3) sends 10 words of code A, then 10 words of code B, then all ones.
- R6: A mode change is applied only at a codeword boundary. The word in progress finishes unchanged, and `tx_bit` changes only after a `bit_en` slot.
- R7: A received code is accepted at the end of the window that brings its 8th hit, as long as no more than 2 windows without a valid codeword occurred in between. `rx_valid` then pulses for one cycle.
- R8: A third window without a valid codeword before the 8th hit discards the candidate, and the hunt starts again bit by bit.
- R9: Accepted codes enter a 4-entry FIFO. `rd_data` shows the oldest entry, a `rd_en` pulse removes it, and codes leave in the order they were accepted.
- R10: A code accepted while the FIFO is full is dropped, and `rd_ovf` is set and stays set until reset.
- R11: `rd_en` while the FIFO is empty has no effect, and `rd_empty` stays 1.
- R12: A code that keeps arriving is reported only once. A different valid code restarts the count, so two codes sent back-to-back are each reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe, high for one cycle per FEAC bit slot |
| rx_bit | input | 1 | Received FEAC bit, sampled when bit_en is high |
| tx_bit | output | 1 | Transmitted FEAC bit for the current slot |
| tx_mode | input | 2 | 0 idle, 1 single burst, 2 continuous, 3 pair |
| tx_code_a | input | 6 | First transmit code |
| tx_code_b | input | 6 | Second transmit code (pair mode) |
| rx_valid | output | 1 | One-cycle pulse when a code is accepted |
| rd_en | input | 1 | Pops the oldest FIFO entry |
| rd_data | output | 6 | Oldest FIFO entry |
| rd_empty | output | 1 | FIFO holds no code |
| rd_ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to bring about is the edge of the 8-of-10 rule. The receive path must see a real codeword stream with invalid windows placed in exact positions. In some cases the hit count reaches 8 exactly on the 10th window, and in others a third miss lands first. The bench turns off loopback and drives hand-built window sequences straight into `rx_bit`, then checks that the acceptance pulse comes exactly at the window the rule predicts. Every other receive case uses the block's own transmitter through loopback. This covers all 64 codes in single-burst mode, code changes in pair mode and FIFO overflow.

// File: rtl/feac_pkg.sv
package feac_pkg;

    localparam int WORD_BITS = 16;
    localparam int CODE_BITS = 6;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SHOT = 2'd1,
        MODE_CONT = 2'd2,
        MODE_PAIR = 2'd3
    } tx_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SHOT,
        TX_CONT,
        TX_PAIR_A,
        TX_PAIR_B,
        TX_DONE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_TRACK,
        RX_HELD
    } rx_state_e;

    function automatic logic [WORD_BITS-1:0] cw_build(input logic [CODE_BITS-1:0] c);
        return {1'b0, c, 1'b0, 8'hFF};
    endfunction

    function automatic logic cw_shape_ok(input logic [WORD_BITS-1:0] w);
        return !w[15] && !w[8] && (&w[7:0]);
    endfunction

    function automatic logic [CODE_BITS-1:0] cw_code(input logic [WORD_BITS-1:0] w);
        return w[14:9];
    endfunction

endpackage

// File: rtl/feac_tx.sv
module feac_tx
    import feac_pkg::*;
#(
    parameter int REP = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic [1:0]           mode,
    input  logic [CODE_BITS-1:0] code_a,
    input  logic [CODE_BITS-1:0] code_b,
    output logic                 tx_bit
);
    localparam int RW = $clog2(REP + 1);
    localparam logic [RW-1:0] REP_W = RW'(REP);

    tx_state_e            st, st_n;
    tx_mode_e             m;
    logic [RW-1:0]        rep, rep_n;
    logic [WORD_BITS-1:0] word, word_n;
    logic [3:0]           slot;
    logic                 redo;

    assign m = tx_mode_e'(mode);

    always_comb begin
        st_n   = st;
        rep_n  = rep;
        word_n = word;
        redo   = 1'b0;
        if (bit_en && slot == 4'd15) begin
            unique case (st)
                TX_IDLE: redo = 1'b1;
                TX_CONT: begin
                    if (m == MODE_CONT) word_n = cw_build(code_a);
                    else                redo   = 1'b1;
                end
                TX_SHOT: begin
                    if (m != MODE_SHOT) redo = 1'b1;
                    else if (rep == REP_W) begin
                        st_n   = TX_DONE;
                        word_n = '1;
                    end else begin
                        word_n = cw_build(code_a);
                        rep_n  = rep + RW'(1);
                    end
                end
                TX_PAIR_A: begin
                    if (m != MODE_PAIR) redo = 1'b1;
                    else if (rep == REP_W) begin
                        st_n   = TX_PAIR_B;
                        word_n = cw_build(code_b);
                        rep_n  = RW'(1);
                    end else begin
                        word_n = cw_build(code_a);
                        rep_n  = rep + RW'(1);
                    end
                end
                TX_PAIR_B: begin
                    if (m != MODE_PAIR) redo = 1'b1;
                    else if (rep == REP_W) begin
                        st_n   = TX_DONE;
                        word_n = '1;
                    end else begin
                        word_n = cw_build(code_b);
                        rep_n  = rep + RW'(1);
                    end
                end
                TX_DONE: begin
                    if (m == MODE_IDLE || m == MODE_CONT) redo   = 1'b1;
                    else                                  word_n = '1;
                end
                default: redo = 1'b1;
            endcase
            if (redo) begin
                unique case (m)
                    MODE_IDLE: begin
                        st_n   = TX_IDLE;
                        word_n = '1;
                        rep_n  = '0;
                    end
                    MODE_SHOT: begin
                        st_n   = TX_SHOT;
                        word_n = cw_build(code_a);
                        rep_n  = RW'(1);
                    end
                    MODE_CONT: begin
                        st_n   = TX_CONT;
                        word_n = cw_build(code_a);
                        rep_n  = '0;
                    end
                    MODE_PAIR: begin
                        st_n   = TX_PAIR_A;
                        word_n = cw_build(code_a);
                        rep_n  = RW'(1);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            rep  <= '0;
            word <= '1;
            slot <= '0;
        end else begin
            st   <= st_n;
            rep  <= rep_n;
            word <= word_n;
            if (bit_en) slot <= slot + 4'd1;
        end
    end

    always_comb begin
        tx_bit = word[4'd15 - slot];
    end

endmodule

// File: rtl/feac_rx.sv
module feac_rx
    import feac_pkg::*;
#(
    parameter int ACC_HITS = 8,
    parameter int WIN      = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 rx_bit,
    output logic                 acc,
    output logic [CODE_BITS-1:0] acc_code
);
    localparam int MISS_LIMIT = WIN - ACC_HITS + 1;
    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] HIT_W  = CW'(ACC_HITS);
    localparam logic [CW-1:0] MISS_W = CW'(MISS_LIMIT);

    rx_state_e            st, st_n;
    logic [WORD_BITS-1:0] sr, sr_n;
    logic [3:0]           slot, slot_n;
    logic [CODE_BITS-1:0] code, code_n;
    logic [CW-1:0]        hits, hits_n, miss, miss_n;
    logic [WIN-1:0]       hist, hist_n;
    logic                 vld, same;

    assign sr_n = {sr[WORD_BITS-2:0], rx_bit};
    assign vld  = cw_shape_ok(sr_n);
    assign same = vld && (cw_code(sr_n) == code);

    always_comb begin
        st_n   = st;
        slot_n = bit_en ? slot + 4'd1 : slot;
        code_n = code;
        hits_n = hits;
        miss_n = miss;
        hist_n = hist;
        acc    = 1'b0;
        if (bit_en) begin
            unique case (st)
                RX_HUNT: begin
                    if (vld) begin
                        st_n   = RX_TRACK;
                        code_n = cw_code(sr_n);
                        hits_n = CW'(1);
                        miss_n = '0;
                        slot_n = '0;
                    end
                end
                RX_TRACK: begin
                    if (slot == 4'd15) begin
                        if (same) begin
                            hits_n = hits + CW'(1);
                            if (hits_n == HIT_W) begin
                                acc    = 1'b1;
                                st_n   = RX_HELD;
                                hist_n = '1;
                            end
                        end else if (vld) begin
                            code_n = cw_code(sr_n);
                            hits_n = CW'(1);
                            miss_n = '0;
                        end else begin
                            miss_n = miss + CW'(1);
                            if (miss_n == MISS_W) st_n = RX_HUNT;
                        end
                    end
                end
                RX_HELD: begin
                    if (slot == 4'd15) begin
                        if (same) begin
                            hist_n = {hist[WIN-2:0], 1'b1};
                        end else if (vld) begin
                            st_n   = RX_TRACK;
                            code_n = cw_code(sr_n);
                            hits_n = CW'(1);
                            miss_n = '0;
                        end else begin
                            hist_n = {hist[WIN-2:0], 1'b0};
                            if ($countones(hist_n) < ACC_HITS) st_n = RX_HUNT;
                        end
                    end
                end
                default: st_n = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_HUNT;
            sr   <= '1;
            slot <= '0;
            code <= '0;
            hits <= '0;
            miss <= '0;
            hist <= '0;
        end else begin
            st   <= st_n;
            if (bit_en) sr <= sr_n;
            slot <= slot_n;
            code <= code_n;
            hits <= hits_n;
            miss <= miss_n;
            hist <= hist_n;
        end
    end

    assign acc_code = code;

endmodule

// File: rtl/feac_fifo.sv
module feac_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   LAST = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            do_push, do_pop;

    assign do_push = push && (cnt != FULL);
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= (wp == LAST) ? '0 : wp + PW'(1);
            end
            if (do_pop) rp <= (rp == LAST) ? '0 : rp + PW'(1);
            if (do_push && !do_pop)      cnt <= cnt + CNTW'(1);
            else if (!do_push && do_pop) cnt <= cnt - CNTW'(1);
            if (push && cnt == FULL) ovf <= 1'b1;
        end
    end

    assign rdata = mem[rp];
    assign empty = (cnt == '0);

endmodule

// File: rtl/feac_ctrl.sv
module feac_ctrl
    import feac_pkg::*;
#(
    parameter int REP        = 10,
    parameter int ACC_HITS   = 8,
    parameter int WIN        = 10,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_bit,
    output logic       tx_bit,
    input  logic [1:0] tx_mode,
    input  logic [5:0] tx_code_a,
    input  logic [5:0] tx_code_b,
    output logic       rx_valid,
    input  logic       rd_en,
    output logic [5:0] rd_data,
    output logic       rd_empty,
    output logic       rd_ovf
);
    logic                 acc;
    logic [CODE_BITS-1:0] acc_code;

    feac_tx #(.REP(REP)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .mode   (tx_mode),
        .code_a (tx_code_a),
        .code_b (tx_code_b),
        .tx_bit (tx_bit)
    );

    feac_rx #(.ACC_HITS(ACC_HITS), .WIN(WIN)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .acc      (acc),
        .acc_code (acc_code)
    );

    feac_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_BITS)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (acc),
        .wdata (acc_code),
        .pop   (rd_en),
        .rdata (rd_data),
        .empty (rd_empty),
        .ovf   (rd_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rx_valid <= 1'b0;
        else        rx_valid <= acc;
    end

endmodule

// File: rtl/feac_ctrl_chk.sv
module feac_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_bit,
    input logic rx_valid,
    input logic rd_empty,
    input logic rd_ovf
);
    AST_TX_HOLD_BETWEEN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(tx_bit)); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovf |=> rd_ovf); // R10
    AST_OVF_ONLY_WHEN_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ovf) |-> !$past(rd_empty)); // R10
    AST_FILL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_empty) |-> rx_valid); // R9
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_empty) && !rx_valid) |-> rd_empty); // R11
endmodule

bind feac_ctrl feac_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .tx_bit   (tx_bit),
    .rx_valid (rx_valid),
    .rd_empty (rd_empty),
    .rd_ovf   (rd_ovf)
);

// File: tb/tb_feac_ctrl.sv
`timescale 1ns/1ps
module tb_feac_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_drv = 1'b1;
    logic       lb = 1'b1;
    logic       rx_bit;
    logic       tx_bit;
    logic [1:0] tx_mode = 2'd0;
    logic [5:0] tx_code_a = '0;
    logic [5:0] tx_code_b = '0;
    logic       rx_valid;
    logic       rd_en = 1'b0;
    logic [5:0] rd_data;
    logic       rd_empty;
    logic       rd_ovf;

    int checks = 0;
    int failures = 0;
    int npulse = 0;
    int slots = 0;
    int ncap = 0;
    bit done = 1'b0;
    logic [15:0] cur_word = '1;
    logic [15:0] cap [64];

    always #2 clk = ~clk;
    assign rx_bit = lb ? tx_bit : rx_drv;

    feac_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .tx_mode(tx_mode), .tx_code_a(tx_code_a), .tx_code_b(tx_code_b),
        .rx_valid(rx_valid), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_ovf(rd_ovf)
    );

    always @(posedge clk) if (rst_n && rx_valid) npulse++;

    function automatic logic [15:0] word_of(input logic [5:0] c);
        return {1'b0, c, 1'b0, 8'hFF};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slot_step(input logic b);
        @(negedge clk);
        rx_drv = b;
        bit_en = 1'b1;
        cur_word = {cur_word[14:0], tx_bit};
        slots++;
        if (slots % 16 == 0 && ncap < 64) begin
            cap[ncap] = cur_word;
            ncap++;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic run_words(input int n);
        for (int i = 0; i < n * 16; i++) slot_step(1'b1);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) slot_step(w[i]);
    endtask

    task automatic pop_one();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic shot(input logic [5:0] c);
        tx_code_a = c;
        tx_mode = 2'd1;
        run_words(14);
        tx_mode = 2'd0;
        run_words(3);
    endtask

    int bad, cnt, p0;
    logic [15:0] exp_w;

    initial begin
        repeat (4) @(negedge clk);
        // R2 reset state
        check(tx_bit == 1'b1, "R2 tx_bit after reset", tx_bit, 1);
        check(rd_empty == 1'b1, "R2 rd_empty after reset", rd_empty, 1);
        check(rd_ovf == 1'b0, "R2 rd_ovf after reset", rd_ovf, 0);
        check(rx_valid == 1'b0, "R2 rx_valid after reset", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 idle output
        ncap = 0;
        run_words(2);
        check(cap[0] == 16'hFFFF && cap[1] == 16'hFFFF, "R2 idle words", cap[1], 16'hFFFF);

        // R11 empty read ignored
        pop_one();
        check(rd_empty == 1'b1, "R11 empty after empty read", rd_empty, 1);

        // R1 R3 R7 R9 sweep over every code, single burst, loopback
        for (int c = 0; c < 64; c++) begin
            ncap = 0;
            p0 = npulse;
            shot(6'(c));
            bad = 0;
            for (int i = 0; i < 17; i++) begin
                exp_w = (i >= 1 && i <= 10) ? word_of(6'(c)) : 16'hFFFF;
                if (cap[i] != exp_w) bad++;
            end
            check(cap[1] == word_of(6'(c)), "R1 word layout", cap[1], word_of(6'(c)));
            check(bad == 0, "R3 ten copies then ones", bad, 0);
            check(npulse - p0 == 1, "R7 one accept per burst", npulse - p0, 1);
            check(!rd_empty && rd_data == 6'(c), "R9 fifo head", rd_data, c);
            pop_one();
            check(rd_empty == 1'b1, "R11 empty after drain", rd_empty, 1);
        end

        // R4 R6 R12 continuous with mid-word stop
        ncap = 0;
        p0 = npulse;
        tx_code_a = 6'h2D;
        tx_mode = 2'd2;
        run_words(20);
        for (int i = 0; i < 5; i++) slot_step(1'b1);
        tx_mode = 2'd0;
        for (int i = 0; i < 11; i++) slot_step(1'b1);
        run_words(3);
        cnt = 0;
        for (int i = 1; i <= 19; i++) if (cap[i] == word_of(6'h2D)) cnt++;
        check(cnt == 19, "R4 continuous words", cnt, 19);
        check(cap[20] == word_of(6'h2D), "R6 word in progress completes", cap[20], word_of(6'h2D));
        check(cap[21] == 16'hFFFF, "R6 stop at boundary", cap[21], 16'hFFFF);
        check(npulse - p0 == 1, "R12 single report for endless code", npulse - p0, 1);
        check(rd_data == 6'h2D, "R9 continuous code stored", rd_data, 6'h2D);
        pop_one();

        // R5 R12 pair mode
        ncap = 0;
        p0 = npulse;
        tx_code_a = 6'h05;
        tx_code_b = 6'h28;
        tx_mode = 2'd3;
        run_words(24);
        tx_mode = 2'd0;
        run_words(3);
        bad = 0;
        for (int i = 0; i < 27; i++) begin
            exp_w = (i >= 1 && i <= 10) ? word_of(6'h05) :
                    (i >= 11 && i <= 20) ? word_of(6'h28) : 16'hFFFF;
            if (cap[i] != exp_w) bad++;
        end
        check(bad == 0, "R5 ten A then ten B then ones", bad, 0);
        check(npulse - p0 == 2, "R12 both pair codes reported", npulse - p0, 2);
        check(rd_data == 6'h05, "R9 pair order first", rd_data, 6'h05);
        pop_one();
        check(rd_data == 6'h28, "R9 pair order second", rd_data, 6'h28);
        pop_one();

        // R7 R8 direct receive edge cases
        lb = 1'b0;
        for (int i = 0; i < 4; i++) send_word(16'hFFFF);
        p0 = npulse;
        send_word(word_of(6'h1A)); send_word(16'hFFFF);
        send_word(word_of(6'h1A)); send_word(16'hFFFF);
        for (int i = 0; i < 5; i++) send_word(word_of(6'h1A));
        check(rx_valid == 1'b0 && npulse == p0, "R7 no accept at seven hits", npulse - p0, 0);
        send_word(word_of(6'h1A));
        check(rx_valid == 1'b1, "R7 accept on eighth hit with two misses", rx_valid, 1);
        for (int i = 0; i < 4; i++) send_word(16'hFFFF);
        check(rd_data == 6'h1A, "R9 direct code stored", rd_data, 6'h1A);
        pop_one();

        p0 = npulse;
        send_word(word_of(6'h33)); send_word(16'hFFFF); send_word(16'hFFFF);
        send_word(word_of(6'h33)); send_word(16'hFFFF);
        for (int i = 0; i < 7; i++) send_word(word_of(6'h33));
        for (int i = 0; i < 4; i++) send_word(16'hFFFF);
        check(npulse == p0, "R8 third miss discards candidate", npulse - p0, 0);
        check(rd_empty == 1'b1, "R8 nothing stored", rd_empty, 1);
        lb = 1'b1;

        // R10 overflow
        for (int c = 10; c < 15; c++) begin
            shot(6'(c));
            if (c == 13) check(rd_ovf == 1'b0, "R10 no overflow at four", rd_ovf, 0);
        end
        check(rd_ovf == 1'b1, "R10 overflow on fifth", rd_ovf, 1);
        for (int c = 10; c < 14; c++) begin
            check(!rd_empty && rd_data == 6'(c), "R10 kept entries in order", rd_data, c);
            pop_one();
        end
        check(rd_empty == 1'b1, "R10 fifth code dropped", rd_empty, 1);
        pop_one();
        check(rd_empty == 1'b1 && rd_ovf == 1'b1, "R11 R10 empty read, flag sticky", rd_ovf, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule